// File: doc/BRIEF.md
# Masked Interrupt Collector with Keyboard Scan Timer

This block gathers four interrupt sources into a single CPU interrupt request: the serial receiver's data-ready flag, the serial transmitter's ready flag, the printer port's acknowledge, and a periodic keyboard-scan tick. The tick comes from a built-in divider of the system clock, set to 10 ms. Each external source is edge-sensitive. A rising edge latches a pending flag whether or not the source is enabled. The CPU sees the flags in a status register where a pending source reads as 0.

Software enables sources through a write-only enable register, where a 1 lets the source drive the request. It acknowledges an external source by writing 0 to its status bit. The scan bit works differently. Software cannot clear it by writing. It clears when the CPU reads the last of the keyboard row registers, and that read also restarts the scan timer. The keyboard matrix and the serial port logic sit outside this block. The block only decodes the row reads for their side effect.

Register select codes are parameters: enable register at 0, status at 1, and keyboard rows at 2 through 11 by default. Bit positions in both registers are fixed: bit 0 receive ready, bit 1 transmit ready, bit 2 printer acknowledge, bit 3 keyboard scan, and bits 7..4 unused.

Top module: `irq_hub`

## Requirements
- R1: After reset the enable register is all zeros, no source is pending, `irq` is low, and the status register reads 8'hFF.
- R2: A rising edge on `rxRdy`, `txRdy` or `parAck` makes status bit 0, 1 or 2 respectively read 0 from the next clock on, even while that source is disabled.
- R3: `irq` is high exactly when some source is pending and its enable bit (bit n of the last value written to the enable address) is 1.
- R4: Writing the status address clears each of bits 0..2 that is written as 0, and leaves unchanged each bit that is written as 1.
- R5: Writing 0 to status bit 3 has no effect on the scan flag.
- R6: The scan flag is set TICK_DIV clocks after the scan timer restarts, and again every TICK_DIV clocks after that.
- R7: A read of the last keyboard row address (ROW_BASE+ROW_COUNT-1) clears the scan flag and restarts the scan timer at zero. Reads of the other row addresses have no effect on either.
- R8: Status bits 7..4 always read 1. Enable bits 7..4 are ignored. A read of any address other than status returns 8'hFF.
- R9: A source held high after its flag is cleared does not set the flag again until it falls and rises once more.
- R10: When a source edge and a clearing write to the same bit land in the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register select code |
| busWr | input | 1 | Write strobe, one clock per access |
| busRd | input | 1 | Read strobe, one clock per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address and strobe |
| rxRdy | input | 1 | Serial receive ready level |
| txRdy | input | 1 | Serial transmit ready level |
| parAck | input | 1 | Printer acknowledge level |
| irq | output | 1 | Interrupt request to the CPU, active high |

## Verification
The hardest case to reach from the ports is a scan tick landing at an exact, known clock. The timer runs freely from reset, so the bench first reads the last row address, which puts the timer at a known zero. It then counts negative clock edges and reads status just before and just after the tick cycle. The clash between a source edge and a clearing write, and the case of a source held high across a clear, are both produced by driving the source level and the bus write on the same falling edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int SRC_N   = 4;  // flags held: three external plus the scan tick
  localparam int EXT_N   = 3;  // edge-detected external sources
  localparam int KEY_BIT = 3;  // position of the scan flag in both registers
  localparam int DATA_W  = 8;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic maskWr;
    logic statWr;
    logic statRd;
    logic lastRowRd;
  } hubStrobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MASK_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int ROW_BASE  = 2,
  parameter int ROW_COUNT = 10
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output hubStrobe_t        strb
);
  localparam int LAST_ROW = ROW_BASE + ROW_COUNT - 1;

  logic [ROW_COUNT-1:0] rowHit;

  // one hit line per keyboard row; only the final one has a side effect
  for (genvar r = 0; r < ROW_COUNT; r++) begin : g_row
    assign rowHit[r] = busRd && (busAddr == ADDR_W'(ROW_BASE + r));
  end

  always_comb begin
    strb           = '0;
    strb.maskWr    = busWr && (busAddr == ADDR_W'(MASK_ADDR));
    strb.statWr    = busWr && (busAddr == ADDR_W'(STAT_ADDR));
    strb.statRd    = busRd && (busAddr == ADDR_W'(STAT_ADDR));
    strb.lastRowRd = rowHit[LAST_ROW - ROW_BASE];
  end
endmodule

// File: rtl/irq_hub_tick.sv
module irq_hub_tick #(
  parameter int TICK_DIV = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN || restart || tick) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hubStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [EXT_N-1:0]  srcLvl,
  input  logic              tick,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [EXT_N-1:0] prevLvl;
  logic [EXT_N-1:0] rise;
  logic [SRC_N-1:0] pend;
  logic [SRC_N-1:0] maskQ;

  assign rise = srcLvl & ~prevLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl <= '0;
      maskQ   <= '0;
    end else begin
      prevLvl <= srcLvl;
      if (strb.maskWr) maskQ <= wdata[SRC_N-1:0];
    end
  end

  // external flags: an edge wins over a clearing write in the same clock
  for (genvar i = 0; i < EXT_N; i++) begin : g_ext
    always_ff @(posedge clk) begin
      if (!rstN)                         pend[i] <= 1'b0;
      else if (rise[i])                  pend[i] <= 1'b1;
      else if (strb.statWr && !wdata[i]) pend[i] <= 1'b0;
    end
  end

  // scan flag: set by the timer, cleared only by the last-row read
  always_ff @(posedge clk) begin
    if (!rstN)               pend[KEY_BIT] <= 1'b0;
    else if (tick)           pend[KEY_BIT] <= 1'b1;
    else if (strb.lastRowRd) pend[KEY_BIT] <= 1'b0;
  end

  assign irq   = |(pend & maskQ);
  assign rdata = strb.statRd ? {{(DATA_W-SRC_N){1'b1}}, ~pend} : {DATA_W{1'b1}};
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MASK_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int ROW_BASE  = 2,
  parameter int ROW_COUNT = 10,
  parameter int TICK_DIV  = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              rxRdy,
  input  logic              txRdy,
  input  logic              parAck,
  output logic              irq
);
  hubStrobe_t strb;
  logic       tickPulse;

  irq_hub_ctrl #(
    .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR),
    .ROW_BASE(ROW_BASE), .ROW_COUNT(ROW_COUNT)
  ) u_ctrl (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .strb(strb)
  );

  irq_hub_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rstN(rstN), .restart(strb.lastRowRd), .tick(tickPulse)
  );

  irq_hub_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .srcLvl({parAck, txRdy, rxRdy}), .tick(tickPulse),
    .rdata(busRdata), .irq(irq)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 1,
  parameter int ROW_BASE  = 2,
  parameter int ROW_COUNT = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic              rxRdy,
  input logic              txRdy,
  input logic              irq,
  input logic [3:0]        pend,
  input logic [3:0]        maskQ,
  input logic              tick
);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] LAST_SEL = ADDR_W'(ROW_BASE + ROW_COUNT - 1);

  // R2
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxRdy) |=> pend[0]);

  // R2
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txRdy) |=> pend[1]);

  // R3
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskQ != 4'h0));

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pend[0]) |-> $past(busWr && busAddr == STAT_SEL && !busWdata[0]));

  // R7
  key_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pend[3]) |-> $past(busRd && busAddr == LAST_SEL));

  // R6
  key_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend[3]) |-> $past(tick));
endmodule

bind irq_hub irq_hub_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
  .ROW_BASE(ROW_BASE), .ROW_COUNT(ROW_COUNT)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .rxRdy(rxRdy), .txRdy(txRdy), .irq(irq),
  .pend(u_dp.pend), .maskQ(u_dp.maskQ), .tick(tickPulse)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  localparam int ADDR_W   = 4;
  localparam int TICK_DIV = 200;
  localparam logic [3:0] A_MASK = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [3:0] A_ROW0 = 4'd2;
  localparam logic [3:0] A_LAST = 4'd11;
  localparam logic [3:0] A_FREE = 4'd15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       rxRdy = 1'b0;
  logic       txRdy = 1'b0;
  logic       parAck = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  irq_hub #(.ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxRdy(rxRdy), .txRdy(txRdy),
    .parAck(parAck), .irq(irq)
  );

  // monitor: compares read data a quarter period after the falling edge
  always @(negedge clk) begin
    #5;
    if (busRd) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, got %h", busRdata);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdata !== e) begin
          errors++;
          $display("FAIL %s: read data %h expected %h", t, busRdata, e);
        end
      end
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    #5;
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq %b expected %b", t, irq, e);
    end
  endtask

  task automatic pulseSrc(input int which);
    @(negedge clk);
    case (which)
      0: rxRdy = 1'b1;
      1: txRdy = 1'b1;
      default: parAck = 1'b1;
    endcase
    @(negedge clk);
    rxRdy = 1'b0; txRdy = 1'b0; parAck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1");
    rdReg(A_STAT, 8'hFF, "R1");
    rdReg(A_LAST, 8'hFF, "R8");  // also restarts the scan timer

    // R2 edge latches while disabled, R3 disabled source keeps irq low
    pulseSrc(0);
    rdReg(A_STAT, 8'hFE, "R2");
    checkIrq(1'b0, "R3");
    wrReg(A_MASK, 8'hF0);        // R8 upper enable bits ignored
    checkIrq(1'b0, "R8");
    wrReg(A_MASK, 8'h01);
    checkIrq(1'b1, "R3");
    wrReg(A_MASK, 8'h07);

    // R4 writing ones keeps, writing zero clears
    wrReg(A_STAT, 8'hFF);
    rdReg(A_STAT, 8'hFE, "R4");
    wrReg(A_STAT, 8'hFE);
    rdReg(A_STAT, 8'hFF, "R4");
    checkIrq(1'b0, "R4");

    pulseSrc(1);
    pulseSrc(2);
    rdReg(A_STAT, 8'hF9, "R2");
    checkIrq(1'b1, "R3");
    wrReg(A_STAT, 8'hFB);
    rdReg(A_STAT, 8'hFD, "R4");
    wrReg(A_STAT, 8'hFD);
    rdReg(A_STAT, 8'hFF, "R4");
    rdReg(A_MASK, 8'hFF, "R8");
    rdReg(A_FREE, 8'hFF, "R8");

    // R9 level held across a clear does not retrigger
    @(negedge clk); rxRdy = 1'b1;
    repeat (2) @(negedge clk);
    wrReg(A_STAT, 8'hFE);
    repeat (3) @(negedge clk);
    rdReg(A_STAT, 8'hFF, "R9");
    rxRdy = 1'b0;
    repeat (2) @(negedge clk);

    // R10 edge and clearing write in the same clock
    @(negedge clk);
    rxRdy = 1'b1; busAddr = A_STAT; busWdata = 8'hFE; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    rdReg(A_STAT, 8'hFE, "R10");
    rxRdy = 1'b0;
    wrReg(A_STAT, 8'hFE);
    rdReg(A_STAT, 8'hFF, "R10");

    // R6 tick timing from a known restart
    wrReg(A_MASK, 8'h08);
    rdReg(A_LAST, 8'hFF, "R7");
    repeat (TICK_DIV - 2) @(negedge clk);
    rdReg(A_STAT, 8'hFF, "R6");
    rdReg(A_STAT, 8'hF7, "R6");
    checkIrq(1'b1, "R6");

    // R5 write cannot clear the scan flag; R7 other rows leave it
    wrReg(A_STAT, 8'h00);
    rdReg(A_STAT, 8'hF7, "R5");
    rdReg(A_ROW0, 8'hFF, "R7");
    rdReg(A_STAT, 8'hF7, "R7");
    rdReg(A_LAST, 8'hFF, "R7");
    rdReg(A_STAT, 8'hFF, "R7");
    checkIrq(1'b0, "R7");

    // R6 next period after restart
    repeat (TICK_DIV) @(negedge clk);
    rdReg(A_STAT, 8'hF7, "R6");

    repeat (2) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule